// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 8K bytes. The host issues one single-byte read or write at a time over a request/ready handshake. The controller then produces the memory's control sequence. That sequence uses an address bus, a data bus split into output, output-enable and input, two chip selects of opposite polarity, an active-low write strobe and an active-low output enable.

Every minimum interval the memory needs is a nanosecond parameter. The controller turns each one into a clock-cycle count by dividing by the clock-period parameter and rounding up. All waits are cycle counters, so the same RTL serves any clock rate. With the default 10 ns clock the derived counts are:

- read: 15 cycles
- write strobe: 9 cycles
- write tail: 6 cycles
- bus release after a read: 5 cycles

Top module: `sram_ctrl`

## Requirements
- R1: In reset and whenever idle, `mem_sel_no`=1, `mem_sel_o`=0, `mem_we_no`=1, `mem_oe_no`=1, `mem_dq_oe_o`=0 and `ready_o`=1.
- R2: `ready_o` is 1 only when idle. A request is taken on a rising edge with `req_i`=1 and `ready_o`=1, and `addr_i`, `wdata_i` and `write_i` are captured there. Changes to them after that edge have no effect on the transfer.
- R3: A read (`write_i`=0) holds both selects active, `mem_we_no`=1 and `mem_oe_no`=0 for max(ceil(tAA), ceil(tOE), ceil(tRC)) cycles (15 at defaults). It samples `mem_dq_i` at the edge that ends this window, so `ready_o` is low for exactly 15 cycles.
- R4: `rvalid_o` is high for exactly one cycle, starting at the sampling edge (15 edges after the accept edge), with `rdata_o` equal to the byte last written to that address.
- R5: A write (`write_i`=1) holds `mem_we_no`=0 with both selects active and `mem_dq_oe_o`=1 for max(ceil(tWP), ceil(tDS)) cycles (9 at defaults). The data must not change during that time.
- R6: After `mem_we_no` rises, the address and the driven data stay unchanged for max(ceil(tWR), ceil(tDH), ceil(tWC) minus the strobe count) cycles (6 at defaults). A write with no turnaround wait therefore keeps `ready_o` low for 15 cycles.
- R7: `mem_dq_oe_o` is never 1 while `mem_oe_no`=0. After `mem_oe_no` rises, the controller waits ceil(tOHZ) cycles (5 at defaults) before driving. A write accepted g<4 cycles after a read ends keeps `ready_o` low for 19-g cycles.
- R8: `mem_sel_no` is always the inverse of `mem_sel_o`.
- R9: `mem_addr_o` does not change while the selects are active or the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| ready_o | output | 1 | Controller idle, request will be taken |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Host byte address |
| wdata_i | input | 8 | Host write byte |
| rvalid_o | output | 1 | One-cycle read-data strobe |
| rdata_o | output | 8 | Read byte |
| mem_addr_o | output | 13 | Memory address bus |
| mem_dq_o | output | 8 | Memory data, controller side |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Memory data, memory side |
| mem_sel_no | output | 1 | Chip select, active low |
| mem_sel_o | output | 1 | Chip select, active high |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |

## Verification
The bench drives the controller against a behavioural memory. That memory returns inverted data if it is sampled before the address and output-enable access times have elapsed, so a controller that samples one cycle early reads back wrong bytes. The model also records:

- contention if the data bus is driven within the release window after output enable rises
- write strobes that are too short
- data or address that moves too close to the strobe's rising edge
- address cycles shorter than the cycle minimum

The sequences cover the lowest and highest addresses and random addresses, with back-to-back read-after-write and write-after-read. Deliberate idle gaps before a write check that the turnaround wait shrinks as expected, rather than being skipped or applied in full.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_HOLD
  } state_e;

  // ceil(ns / period); zero stays zero
  function automatic int ns_to_cyc(int ns, int period);
    if (ns <= 0) return 0;
    return (ns + period - 1) / period;
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (load_i)          cnt_o <= val_i;
    else if (cnt_o != '0)     cnt_o <= cnt_o - 1'b1;
  end

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int               CNT_W      = 4,
  parameter logic [CNT_W-1:0] RD_LAST    = '0,
  parameter logic [CNT_W-1:0] PULSE_LAST = '0,
  parameter logic [CNT_W-1:0] HOLD_LAST  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             write_i,
  input  logic [CNT_W-1:0] phase_cnt_i,
  input  logic [CNT_W-1:0] turn_cnt_i,
  output state_e           state_q_o,
  output state_e           state_d_o,
  output logic             phase_load_o,
  output logic [CNT_W-1:0] phase_val_o,
  output logic             turn_load_o,
  output logic             accept_o,
  output logic             sample_o
);

  state_e state_q, state_d;
  logic   phase_done, turn_ok;

  assign phase_done = (phase_cnt_i == '0);
  // bus free at the next edge
  assign turn_ok    = (turn_cnt_i <= CNT_W'(1));

  always_comb begin
    state_d      = state_q;
    phase_load_o = 1'b0;
    phase_val_o  = '0;
    turn_load_o  = 1'b0;
    accept_o     = 1'b0;
    sample_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        if (write_i) begin
          if (turn_ok) begin
            state_d      = ST_WR_PULSE;
            phase_load_o = 1'b1;
            phase_val_o  = PULSE_LAST;
          end else begin
            state_d = ST_WR_TURN;
          end
        end else begin
          state_d      = ST_RD;
          phase_load_o = 1'b1;
          phase_val_o  = RD_LAST;
        end
      end
      ST_WR_TURN: if (turn_ok) begin
        state_d      = ST_WR_PULSE;
        phase_load_o = 1'b1;
        phase_val_o  = PULSE_LAST;
      end
      ST_WR_PULSE: if (phase_done) begin
        state_d      = ST_WR_HOLD;
        phase_load_o = 1'b1;
        phase_val_o  = HOLD_LAST;
      end
      ST_WR_HOLD: if (phase_done) state_d = ST_IDLE;
      ST_RD: if (phase_done) begin
        state_d     = ST_IDLE;
        sample_o    = 1'b1;
        turn_load_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (state_q != ST_IDLE));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int AW      = 13,
  parameter int DW      = 8,
  parameter int T_RC_NS = 150,
  parameter int T_AA_NS = 150,
  parameter int T_OE_NS = 70,
  parameter int T_WC_NS = 150,
  parameter int T_WP_NS = 90,
  parameter int T_WR_NS = 10,
  parameter int T_DS_NS = 60,
  parameter int T_DH_NS = 5,
  parameter int T_HZ_NS = 50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  output logic          ready_o,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_sel_no,
  output logic          mem_sel_o,
  output logic          mem_we_no,
  output logic          mem_oe_no
);

  localparam int RD_CYC    = max_of(1, max_of(max_of(ns_to_cyc(T_AA_NS, CLK_NS),
                                                     ns_to_cyc(T_OE_NS, CLK_NS)),
                                              ns_to_cyc(T_RC_NS, CLK_NS)));
  localparam int PULSE_CYC = max_of(1, max_of(ns_to_cyc(T_WP_NS, CLK_NS),
                                              ns_to_cyc(T_DS_NS, CLK_NS)));
  localparam int HOLD_CYC  = max_of(1, max_of(max_of(ns_to_cyc(T_WR_NS, CLK_NS),
                                                     ns_to_cyc(T_DH_NS, CLK_NS)),
                                              ns_to_cyc(T_WC_NS, CLK_NS) - PULSE_CYC));
  localparam int TURN_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC   = max_of(max_of(RD_CYC, PULSE_CYC), max_of(HOLD_CYC, TURN_CYC));
  localparam int CNT_W     = max_of(1, $clog2(MAX_CYC + 1));

  state_e           state_q, state_d;
  logic             phase_load, turn_load, accept, sample;
  logic [CNT_W-1:0] phase_val, phase_cnt, turn_cnt;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic             rvalid_q, sel_q, we_q, oe_q, dq_oe_q;

  sram_ctrl_fsm #(
    .CNT_W      (CNT_W),
    .RD_LAST    (CNT_W'(RD_CYC - 1)),
    .PULSE_LAST (CNT_W'(PULSE_CYC - 1)),
    .HOLD_LAST  (CNT_W'(HOLD_CYC - 1))
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .write_i      (write_i),
    .phase_cnt_i  (phase_cnt),
    .turn_cnt_i   (turn_cnt),
    .state_q_o    (state_q),
    .state_d_o    (state_d),
    .phase_load_o (phase_load),
    .phase_val_o  (phase_val),
    .turn_load_o  (turn_load),
    .accept_o     (accept),
    .sample_o     (sample)
  );

  sram_ctrl_timer #(.W(CNT_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (phase_load),
    .val_i  (phase_val),
    .cnt_o  (phase_cnt)
  );

  sram_ctrl_timer #(.W(CNT_W)) u_turn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (turn_load),
    .val_i  (CNT_W'(TURN_CYC)),
    .cnt_o  (turn_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= sample;
      if (sample) rdata_q <= mem_dq_i;
    end
  end

  // strobes registered from next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
      dq_oe_q <= 1'b0;
    end else begin
      sel_q   <= (state_d == ST_RD) || (state_d == ST_WR_PULSE);
      we_q    <= (state_d == ST_WR_PULSE);
      oe_q    <= (state_d == ST_RD);
      dq_oe_q <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = dq_oe_q;
  assign mem_sel_no  = ~sel_q;
  assign mem_sel_o   = sel_q;
  assign mem_we_no   = ~we_q;
  assign mem_oe_no   = ~oe_q;

  // checker counters
  localparam logic [CNT_W:0] SAT = '1;
  logic [CNT_W:0] since_oe, oe_run, we_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_oe <= SAT;
      oe_run   <= '0;
      we_run   <= '0;
    end else begin
      if (!mem_oe_no)          since_oe <= '0;
      else if (since_oe != SAT) since_oe <= since_oe + 1'b1;
      if (accept)                          oe_run <= '0;
      else if (!mem_oe_no && oe_run != SAT) oe_run <= oe_run + 1'b1;
      if (accept)                          we_run <= '0;
      else if (!mem_we_no && we_run != SAT) we_run <= we_run + 1'b1;
    end
  end

  a_r1_idle_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_sel_no && !mem_sel_o && mem_we_no && mem_oe_no && !mem_dq_oe_o));

  a_r3_read_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (oe_run == (CNT_W+1)'(RD_CYC)));

  a_r4_rvalid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  a_r5_strobe_ctx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_sel_no && mem_dq_oe_o && mem_oe_no));

  a_r5_strobe_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (we_run == (CNT_W+1)'(PULSE_CYC)));

  a_r6_tail_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (mem_dq_oe_o && $stable(mem_addr_o) && $stable(mem_dq_o)));

  a_r7_no_drive_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  a_r7_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (since_oe >= (CNT_W+1)'(TURN_CYC)));

  a_r8_sel_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_no == !mem_sel_o);

  a_r9_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_sel_no && $past(!mem_sel_no)) |-> $stable(mem_addr_o));

endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int T_AA = 150, T_OE = 70, T_CYC = 150, T_WP = 90, T_DS = 60, T_HZ = 50;
  localparam int RD_BUSY = 15, WR_BUSY = 15, TURN = 5;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_i = 1'b0, write_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       ready_o, rvalid_o, mem_dq_oe_o, mem_sel_no, mem_sel_o, mem_we_no, mem_oe_no;
  logic [7:0] rdata_o, mem_dq_o;
  logic [7:0] mem_dq_i = '0;
  logic [12:0] mem_addr_o;

  always #5 clk = ~clk;

  sram_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .ready_o(ready_o), .write_i(write_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
    .mem_dq_i(mem_dq_i), .mem_sel_no(mem_sel_no), .mem_sel_o(mem_sel_o),
    .mem_we_no(mem_we_no), .mem_oe_no(mem_oe_no)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // behavioural memory with timing watch
  byte unsigned model_mem[int];
  int a_age = 1000, oe_age = 0, oe_rel = 1000, we_low = 0, d_age = 0;
  int v_cont = 0, v_oewe = 0, v_sel = 0, v_wp = 0, v_ds = 0, v_dh = 0, v_ah = 0, v_cyc = 0;
  bit epoch_used = 0;
  logic [12:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  logic        p_dq_oe = 0, p_we_n = 1, p_oe_n = 1, p_sel = 0;

  function automatic logic [7:0] mem_at(logic [12:0] a);
    if (model_mem.exists(int'(a))) return model_mem[int'(a)];
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit sel = !mem_sel_no && mem_sel_o;
      automatic bit we_rise = mem_we_n_rise();
      automatic bit addr_chg = (mem_addr_o != p_addr);
      if (mem_sel_no == mem_sel_o) v_sel++;
      if (!mem_we_no && !mem_oe_no) v_oewe++;
      if (mem_oe_no && !p_oe_n) oe_rel = 1;
      else if (mem_oe_no && oe_rel < 1000) oe_rel++;
      if (mem_dq_oe_o && (!mem_oe_no || oe_rel * CLK_NS < T_HZ + CLK_NS)) v_cont++;
      if (we_rise) begin
        if (we_low * CLK_NS < T_WP) v_wp++;
        if (d_age * CLK_NS < T_DS) v_ds++;
        if (!mem_dq_oe_o || mem_dq_o != p_dq) v_dh++;
        if (addr_chg) v_ah++;
        if (p_sel && p_dq_oe) model_mem[int'(p_addr)] = p_dq;
      end
      if (addr_chg) begin
        if (!p_we_n) v_ah++;
        if (epoch_used && a_age * CLK_NS < T_CYC) v_cyc++;
        a_age = 1;
        epoch_used = 0;
      end else if (a_age < 1000) a_age++;
      if (sel) epoch_used = 1;
      if (!mem_we_no) we_low = p_we_n ? 1 : we_low + 1;
      if (mem_dq_oe_o && p_dq_oe && mem_dq_o == p_dq) d_age++;
      else d_age = mem_dq_oe_o ? 1 : 0;
      if (!mem_oe_no) oe_age = p_oe_n ? 1 : oe_age + 1;
      if (sel && mem_we_no && !mem_oe_no)
        mem_dq_i = (a_age * CLK_NS >= T_AA && oe_age * CLK_NS >= T_OE) ?
                   mem_at(mem_addr_o) : ~mem_at(mem_addr_o);
      else mem_dq_i = 8'h00;
      p_addr = mem_addr_o; p_dq = mem_dq_o; p_dq_oe = mem_dq_oe_o;
      p_we_n = mem_we_no; p_oe_n = mem_oe_no; p_sel = sel;
    end
  end

  function automatic bit mem_we_n_rise();
    return mem_we_no && !p_we_n;
  endfunction

  // scoreboard
  typedef struct { logic [7:0] d; int acc; int a; } exp_t;
  exp_t exp_q[$];
  logic [7:0] ref_mem[int];
  bit p_rv = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid_o) begin
        if (exp_q.size() == 0) chk(0, "R4", "unexpected rvalid", 1, 0);
        else begin
          automatic exp_t e = exp_q.pop_front();
          chk(rdata_o == e.d, "R3", $sformatf("read data @%0h", e.a), rdata_o, e.d);
          chk(cyc - e.acc == RD_BUSY, "R4", "rvalid latency", cyc - e.acc, RD_BUSY);
        end
      end
      if (rvalid_o && p_rv) chk(0, "R4", "rvalid longer than one cycle", 2, 1);
      p_rv = rvalid_o;
    end
  end

  bit last_rd = 0;

  task automatic op(bit wr, logic [12:0] a, logic [7:0] d, int gap);
    int busy, exp_busy;
    repeat (gap) @(negedge clk);
    while (!ready_o) @(negedge clk);
    if (!wr) exp_busy = RD_BUSY;
    else if (last_rd && gap < TURN - 1) exp_busy = WR_BUSY + TURN - 1 - gap;
    else exp_busy = WR_BUSY;
    req_i = 1; write_i = wr; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    if (wr) ref_mem[int'(a)] = d;
    else exp_q.push_back('{ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00, cyc, int'(a)});
    @(negedge clk);
    // R2: scrambled inputs after the accept edge must be ignored
    req_i = 0; write_i = ~wr; addr_i = ~a; wdata_i = ~d;
    busy = 0;
    while (!ready_o) begin busy++; @(negedge clk); end
    chk(busy == exp_busy, wr ? (exp_busy != WR_BUSY ? "R7" : "R6") : "R3",
        $sformatf("busy cycles %s @%0h gap %0d", wr ? "wr" : "rd", a, gap), busy, exp_busy);
    last_rd = !wr;
  endtask

  task automatic chk_idle(string what);
    chk(mem_sel_no && !mem_sel_o && mem_we_no && mem_oe_no && !mem_dq_oe_o && ready_o,
        "R1", what, {mem_sel_no, mem_sel_o, mem_we_no, mem_oe_no, mem_dq_oe_o, ready_o}, 6'b101101);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [12:0] ra;
    logic [7:0]  rd;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("levels in reset");
    rst_n = 1;
    @(negedge clk);
    chk_idle("levels after reset");

    op(1, 13'h0000, 8'h5A, 0);
    op(1, 13'h1FFF, 8'hC3, 0);
    op(0, 13'h0000, 8'h00, 0);
    op(1, 13'h0001, 8'h3C, 0);          // write right after read
    op(0, 13'h1FFF, 8'h00, 0);
    op(0, 13'h0001, 8'h00, 0);
    op(1, 13'h0123, 8'h77, 1);          // gap 1 after read
    op(0, 13'h0123, 8'h00, 0);
    op(1, 13'h0124, 8'h88, 3);          // gap 3 after read
    op(0, 13'h0124, 8'h00, 0);
    op(1, 13'h0125, 8'h99, 6);          // turnaround fully expired
    op(0, 13'h0125, 8'h00, 0);
    for (int b = 0; b < 8; b++) begin
      op(1, 13'h0AAA, 8'(1 << b), 0);
      op(0, 13'h0AAA, 8'h00, 0);
    end
    for (int i = 0; i < 24; i++) begin
      ra = 13'($urandom);
      rd = 8'($urandom);
      op(1, ra, rd, 0);
      op(0, ra, 8'h00, 0);
      op(0, 13'h1FFF, 8'h00, 0);
    end
    op(0, 13'h0000, 8'h00, 0);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "reads left without rvalid", exp_q.size(), 0);
    chk_idle("levels when idle at end");
    chk(v_cont == 0, "R7", "bus contention events", v_cont, 0);
    chk(v_oewe == 0, "R7", "strobe with output enable low", v_oewe, 0);
    chk(v_sel == 0, "R8", "select polarity mismatch", v_sel, 0);
    chk(v_wp == 0, "R5", "short write strobe", v_wp, 0);
    chk(v_ds == 0, "R5", "data setup short", v_ds, 0);
    chk(v_dh == 0, "R6", "data hold short", v_dh, 0);
    chk(v_ah == 0, "R9", "address moved near strobe", v_ah, 0);
    chk(v_cyc == 0, "R6", "address cycle too short", v_cyc, 0);
    report();
  end
endmodule